// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to 31 level-sensitive interrupt sources and drives one active-high request line to a processor. Each source has an enable bit, a 3-bit priority and a 32-bit handler address. The block does not pick a winner when the request rises. It picks one when software reads the vector register. That read returns the winner's handler address and makes the winner the current interrupt. Writing the end-of-interrupt register drops back to the interrupted context.

An 8-entry context stack holds the source number and priority of every interrupt in service. Because of this stack, a higher-priority interrupt can pre-empt a handler that is already running. The request line is raised only for a source whose priority is strictly above the one in service. Before the first interrupt is taken, any enabled pending source may raise it. Registers are reached through a simple valid/write/word-address/data port. Read data appears on the cycle after the access.

Word map (address bits [6:5] select the region; bits [4:0] select the source or the control register):
- Region 0, word n: priority of source n, in bits [2:0].
- Region 1, word n: handler address of source n.
- Region 2, words 0x40 to 0x46:
  - 0x40: enable-set. A 1 sets that enable.
  - 0x41: enable-clear. A 1 clears that enable.
  - 0x42: vector read.
  - 0x43: end-of-interrupt write.
  - 0x44: current context. Bits [4:0] hold the source, bits [7:5] the priority, and bit 8 is the idle flag.
  - 0x45: default vector.
  - 0x46: enable mask.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset:
  - `irq` is 0.
  - All enables are clear.
  - All priorities and the default vector read 0.
  - The current-context word (0x44) reads 0x100, meaning idle.
- R2: `irq` goes to 1 within two clock cycles once an enabled source n (1 to 31) is pending and either nothing is in service or its priority is strictly greater than the current priority. A disabled source, source 0, or a source at or below the current priority does not raise it.
- R3: A read of 0x42 selects, among the sources qualifying under R2 at the moment of the read, the one with the highest priority. Sources that became pending after `irq` rose are included.
- R4: Among qualifying sources of equal priority, the lowest source number is selected.
- R5: A vector read that selects source n returns the value last written to word 0x20+n.
- R6: A vector read that selects a source makes it current, and 0x44 then shows its number and priority. A source at or below that priority, including the taken one, no longer drives `irq`.
- R7: A write to 0x43 restores the previous context. A source that was held off by the priority rule then raises `irq` again.
- R8: Contexts nest eight deep, one per priority level. End-of-interrupt writes restore them in reverse order, down to idle.
- R9: A vector read when no source qualifies returns the default vector (0x45) and leaves the current context unchanged.
- R10: An end-of-interrupt write while idle has no effect: 0x44 stays 0x100.
- R11: Writing to 0x40 or 0x41 sets or clears the enables whose bits are 1. Bit 0 always reads 0 in the mask at 0x46.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pend | input | 32 | Level pending bit per source; bit 0 unused |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 7 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the access |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A corrupted context stack shows up in two ways. The current-context word at 0x44 would read a wrong number, and `irq` would rise or fail to rise within two cycles of an end-of-interrupt write. A fault in the arbiter shows on the very next vector read, because the returned handler address names the wrong source. A wrong enable or priority bit shows up either in the mask readback or as a wrong winner when several sources are pending. The directed sequences therefore compare 0x44 and `irq` after every push and pop, and compare each returned address with the one the rules predict.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int OFF_EN_SET  = 0;
  localparam int OFF_EN_CLR  = 1;
  localparam int OFF_VEC_RD  = 2;
  localparam int OFF_EOI     = 3;
  localparam int OFF_CUR     = 4;
  localparam int OFF_DEFVEC  = 5;
  localparam int OFF_EN_MASK = 6;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_VEC  = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        req,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx,
  output logic [PRIO_W-1:0]      win_prio
);
  // Scan downward: ">=" lets a lower index win a tie.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = NSRC - 1; i >= 1; i--) begin
      if (req[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] >= win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
  parameter int DEPTH  = 8,
  parameter int SRC_W  = 5,
  parameter int PRIO_W = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [SRC_W-1:0]  push_src,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [SRC_W-1:0]  cur_src,
  output logic [PRIO_W-1:0] cur_prio,
  output logic              idle
);
  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [PRIO_W-1:0] prio;
  } ctx_t;

  ctx_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_ptr;

  assign top_ptr  = cnt - 1'b1;
  assign idle     = (cnt == '0);
  assign cur_src  = idle ? '0 : mem[top_ptr[PTR_W-1:0]].src;
  assign cur_prio = idle ? '0 : mem[top_ptr[PTR_W-1:0]].prio;

  always_ff @(posedge clk) begin
    if (push) mem[cnt[PTR_W-1:0]] <= '{src: push_src, prio: push_prio};
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (push) cnt <= cnt + 1'b1;
    else if (pop)  cnt <= cnt - 1'b1;
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> cnt < CNT_W'(DEPTH));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0);
  assert_nest_rises_R8: assert property (@(posedge clk) disable iff (rst)
    (push && !idle) |=> cur_prio > $past(cur_prio));
endmodule

// File: rtl/nic_vec_ram.sv
module nic_vec_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NSRC        = 32,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 8,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NSRC),
  localparam int ADDR_W     = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_pend,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import nic_pkg::*;

  logic [PRIO_W-1:0]      prio_q [NSRC];
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]        en_q;
  logic [DATA_W-1:0]      defvec_q;
  logic [NSRC-1:0]        qual;
  logic                   win_valid;
  logic [IDX_W-1:0]       win_idx;
  logic [PRIO_W-1:0]      win_prio;
  logic [IDX_W-1:0]       cur_src;
  logic [PRIO_W-1:0]      cur_prio;
  logic                   idle;
  logic                   irq_q;
  logic [DATA_W-1:0]      ram_q;
  logic [DATA_W-1:0]      rdata_q;
  logic                   rsel_ram_q;

  region_e          region;
  logic [IDX_W-1:0] sub;
  logic             wr, rd, ctl_wr, ctl_rd, rd_vec, push, pop;

  assign region = region_e'(reg_addr[ADDR_W-1 -: 2]);
  assign sub    = reg_addr[IDX_W-1:0];
  assign wr     = reg_valid && reg_write;
  assign rd     = reg_valid && !reg_write;
  assign ctl_wr = wr && region == REG_CTRL;
  assign ctl_rd = rd && region == REG_CTRL;
  assign rd_vec = ctl_rd && sub == IDX_W'(OFF_VEC_RD);
  assign push   = rd_vec && win_valid;
  assign pop    = ctl_wr && sub == IDX_W'(OFF_EOI) && !idle;

  // A source qualifies when enabled, pending and above the level in service.
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
      if (i == 0) begin : g_unused
        assign qual[i] = 1'b0;
      end else begin : g_live
        assign qual[i] = en_q[i] && src_pend[i] && (idle || prio_q[i] > cur_prio);
      end
    end
  endgenerate

  nic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .req(qual), .prio_flat(prio_flat),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  nic_stack #(.DEPTH(STACK_DEPTH), .SRC_W(IDX_W), .PRIO_W(PRIO_W)) u_stk (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_src(win_idx), .push_prio(win_prio),
    .cur_src(cur_src), .cur_prio(cur_prio), .idle(idle)
  );

  nic_vec_ram #(.DEPTH(NSRC), .W(DATA_W)) u_vec (
    .clk(clk), .we(wr && region == REG_VEC), .waddr(sub), .wdata(reg_wdata),
    .raddr(rd_vec ? win_idx : sub), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else if (wr && region == REG_MODE) begin
      prio_q[sub] <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      defvec_q <= '0;
    end else if (ctl_wr) begin
      case (int'(sub))
        OFF_EN_SET: en_q     <= (en_q | reg_wdata[NSRC-1:0]) & ~NSRC'(1);
        OFF_EN_CLR: en_q     <= en_q & ~reg_wdata[NSRC-1:0];
        OFF_DEFVEC: defvec_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_ram_q <= 1'b0;
      rdata_q    <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q      <= |qual;
      rsel_ram_q <= push || (rd && region == REG_VEC);
      rdata_q    <= '0;
      if (rd && region == REG_MODE) begin
        rdata_q <= DATA_W'(prio_q[sub]);
      end else if (ctl_rd) begin
        case (int'(sub))
          OFF_VEC_RD:  rdata_q <= defvec_q;
          OFF_CUR:     rdata_q <= DATA_W'({idle, cur_prio, cur_src});
          OFF_DEFVEC:  rdata_q <= defvec_q;
          OFF_EN_MASK: rdata_q <= DATA_W'(en_q);
          default: ;
        endcase
      end
    end
  end

  assign reg_rdata = rsel_ram_q ? ram_q : rdata_q;
  assign irq       = irq_q;

  assert_win_above_cur_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> (idle || win_prio > cur_prio));
  assert_win_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (en_q[win_idx] && src_pend[win_idx] && win_idx != '0));
  assert_eoi_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && sub == IDX_W'(OFF_EOI) && idle) |=> idle);
  assert_pop_restores_R7: assert property (@(posedge clk) disable iff (rst)
    pop |=> (idle || cur_prio < $past(cur_prio)));
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_pend = '0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nest_irq_ctrl dut (
    .clk(clk), .rst(rst), .src_pend(src_pend), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] vec_of(int n);
    return 32'hA000_0000 + 32'(n * 4);
  endfunction

  function automatic logic [31:0] cur_word(int src, int pr);
    return 32'((pr << 5) | src);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = 7'(addr); reg_wdata = data;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = 7'(addr);
    @(negedge clk);
    reg_valid = 0;
    data = reg_rdata;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk_eq("R1 irq", 32'(irq), 0);
    rd(7'h44, d); chk_eq("R1 current", d, 32'h100);
    rd(7'h46, d); chk_eq("R1 enables", d, 0);
    rd(7'h45, d); chk_eq("R1 default", d, 0);
    rd(7'h05, d); chk_eq("R1 priority", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(7'h40, 32'hFFFF_FFFF);
    rd(7'h46, d); chk_eq("R11 set all", d, 32'hFFFF_FFFE);
    wr(7'h41, 32'h0000_00F0);
    rd(7'h46, d); chk_eq("R11 clear some", d, 32'hFFFF_FF0E);
    wr(7'h41, 32'hFFFF_FFFF);
    rd(7'h46, d); chk_eq("R11 clear all", d, 0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    wr(7'h03, 2);
    src_pend[3] = 1;
    idle_cycles(3); chk_eq("R2 disabled", 32'(irq), 0);
    wr(7'h40, 32'h8);
    idle_cycles(2); chk_eq("R2 raise", 32'(irq), 1);
    rd(7'h42, d); chk_eq("R5 vector", d, vec_of(3));
    rd(7'h44, d); chk_eq("R6 current", d, cur_word(3, 2));
    idle_cycles(2); chk_eq("R6 same level held", 32'(irq), 0);
    wr(7'h43, 0);
    rd(7'h44, d); chk_eq("R7 pop idle", d, 32'h100);
    idle_cycles(1); chk_eq("R7 re-raise", 32'(irq), 1);
    src_pend[3] = 0;
    wr(7'h41, 32'h8);
    idle_cycles(2); chk_eq("R2 drop", 32'(irq), 0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    wr(7'h05, 1); wr(7'h09, 6); wr(7'h14, 6); wr(7'h02, 3);
    rd(7'h09, d); chk_eq("R3 mode readback", d, 6);
    wr(7'h40, (1 << 5) | (1 << 9) | (1 << 20) | (1 << 2));
    src_pend[5] = 1;
    idle_cycles(2); chk_eq("R2 low prio raise", 32'(irq), 1);
    src_pend[9] = 1; src_pend[20] = 1; src_pend[2] = 1;
    rd(7'h42, d); chk_eq("R3 R4 late higher, tie low number", d, vec_of(9));
    rd(7'h44, d); chk_eq("R6 current 9", d, cur_word(9, 6));
    idle_cycles(2); chk_eq("R2 equal prio held", 32'(irq), 0);
    wr(7'h43, 0);
    idle_cycles(2); chk_eq("R7 raise after eoi", 32'(irq), 1);
    src_pend[9] = 0;
    rd(7'h42, d); chk_eq("R4 next in tie", d, vec_of(20));
    wr(7'h43, 0);
    src_pend = '0;
    wr(7'h41, 32'hFFFF_FFFF);
  endtask

  task automatic t_nest;
    logic [31:0] d;
    for (int n = 1; n <= 8; n++) wr(n, n - 1);
    wr(7'h0A, 7);
    wr(7'h40, 32'h0000_05FE);
    for (int n = 1; n <= 8; n++) begin
      src_pend[n] = 1;
      idle_cycles(2); chk_eq($sformatf("R2 nest raise %0d", n), 32'(irq), 1);
      rd(7'h42, d); chk_eq($sformatf("R8 nest vector %0d", n), d, vec_of(n));
    end
    rd(7'h44, d); chk_eq("R8 deepest", d, cur_word(8, 7));
    src_pend[10] = 1;
    idle_cycles(3); chk_eq("R2 top level blocks equal", 32'(irq), 0);
    for (int k = 7; k >= 1; k--) begin
      wr(7'h43, 0);
      rd(7'h44, d); chk_eq($sformatf("R8 unwind %0d", k), d, cur_word(k, k - 1));
    end
    wr(7'h43, 0);
    rd(7'h44, d); chk_eq("R8 unwind idle", d, 32'h100);
    src_pend = '0;
    wr(7'h41, 32'hFFFF_FFFF);
  endtask

  task automatic t_default;
    logic [31:0] d;
    wr(7'h45, 32'hDEAD_0000);
    rd(7'h42, d); chk_eq("R9 default vector", d, 32'hDEAD_0000);
    rd(7'h44, d); chk_eq("R9 no push", d, 32'h100);
  endtask

  task automatic t_eoi_idle;
    logic [31:0] d;
    wr(7'h43, 0);
    rd(7'h44, d); chk_eq("R10 eoi idle", d, 32'h100);
    wr(7'h0C, 4); wr(7'h40, 32'h1000); src_pend[12] = 1;
    idle_cycles(2);
    wr(7'h43, 0);
    idle_cycles(2); chk_eq("R10 irq kept", 32'(irq), 1);
    rd(7'h42, d); chk_eq("R10 later vector", d, vec_of(12));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    for (int n = 1; n < 32; n++) wr(7'h20 + n, vec_of(n));
    t_enable();
    t_basic();
    t_priority();
    t_nest();
    t_default();
    t_eoi_idle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule